// File: doc/BRIEF.md
# Floating-Point Minimum/Maximum Select Unit

This block picks one of two IEEE-754 operands as the larger or the smaller of the pair. It is purely combinational: the result is available in the same cycle the operands are presented. A two-bit function code selects one of four variants. The plain maximum and minimum variants let any NaN win. The number-preferring variants (max-number, min-number) treat a single quiet NaN as absent data. A format bit selects binary32 or binary64. Both operands and the result are raw bit patterns on 64-bit buses.

NaNs resolve under a fixed priority. A signalling NaN is always reported on a separate invalid line, and the signalling NaN that is chosen is returned with its quiet bit set and its payload kept. Zeros of opposite sign are ordered explicitly, so the maximum of +0 and -0 is +0 and the minimum is -0. Non-NaN operands pass through bit-exactly. The unit is meant to sit in the execute stage of a floating-point pipeline, next to the adder, with the surrounding stage registers owned by the pipeline.

Top module: `fp_minmax_unit`

## Requirements
- R1: With no NaN and not both operands zero, function code 2'b00 (maximum) returns the numerically larger operand bit-exactly and code 2'b01 (minimum) returns the smaller. When both operands are negative, the operand with the larger magnitude is the smaller value.
- R2: When a NaN is present, the result comes from the first of these that applies: a signalling NaN in operand A, a signalling NaN in operand B, a quiet NaN in operand A, a quiet NaN in operand B. A NaN has an all-ones exponent and a nonzero fraction. It is quiet when the fraction MSB is 1 and signalling when that bit is 0.
- R3: A chosen signalling NaN is returned with its fraction MSB forced to 1 and every other bit unchanged. That bit is bit 22 in binary32 and bit 51 in binary64.
- R4: When both operands are quiet NaNs, operand A is returned unchanged, under every function code.
- R5: Maximum of two zeros returns +0 unless both are -0, in which case it returns -0.
- R6: Minimum of two zeros returns -0 unless both are +0, in which case it returns +0.
- R7: Code 2'b10 (max-number) replaces a lone quiet NaN with -infinity and then applies the maximum rules. Code 2'b11 (min-number) replaces it with +infinity and then applies the minimum rules. The other operand is therefore returned.
- R8: Under codes 2'b10 and 2'b11, a signalling NaN is never replaced and follows R2 and R3.
- R9: With the format bit at 0 (binary32), only bits 31:0 of each operand are used, bits 63:32 of the operands have no effect, and bits 63:32 of the result are 0. With the format bit at 1, all 64 bits form a binary64 value.
- R10: The invalid output is 1 exactly when either operand, read in the selected format, is a signalling NaN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| func_sel | input | 2 | 00 maximum, 01 minimum, 10 max-number, 11 min-number |
| is_double | input | 1 | 1 selects binary64, 0 selects binary32 in bits 31:0 |
| opnd_a | input | 64 | First operand, raw bits |
| opnd_b | input | 64 | Second operand, raw bits |
| result | output | 64 | Selected value, raw bits |
| invalid | output | 1 | Either operand is a signalling NaN |

## Verification
Ordinary pairs are tried positive against positive, negative against negative, and across signs, including denormals and the largest finite values. A swapped magnitude comparison or a missing sign flip therefore shows up in only some of these groups. NaN pairs are tried in both operand orders, with signalling against quiet, signalling against signalling, and quiet against quiet. This separates a wrong priority from a missing quieting step. All four zero-sign combinations are applied under both maximum and minimum. In binary32 mode the upper operand bits are filled with patterns that would change the answer if they leaked into the comparison or the invalid detection.

// File: rtl/fmm_pkg.sv
package fmm_pkg;

   // Function code: bit 0 selects the smaller value, bit 1 the number-preferring form
   typedef enum logic [1:0] {
      FMM_MAX    = 2'b00,
      FMM_MIN    = 2'b01,
      FMM_MAXNUM = 2'b10,
      FMM_MINNUM = 2'b11
   } fmm_func_e;

   typedef struct packed {
      logic sign;
      logic zero;
      logic inf;
      logic qnan;
      logic snan;
   } fmm_cls_t;

   function automatic logic fmm_wants_min(input logic [1:0] f);
      return f[0];
   endfunction

   function automatic logic fmm_prefers_num(input logic [1:0] f);
      return f[1];
   endfunction

endpackage

// File: rtl/fmm_classify.sv
module fmm_classify
   import fmm_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W:0] val,
   output fmm_cls_t              cls
);
   localparam int W = 1 + EXP_W + FRAC_W;

   logic exp_ones;
   logic exp_zero;
   logic frac_nz;
   logic frac_top;

   if (EXP_W < 2 || FRAC_W < 2) begin : g_bad_fmt
      $error("fmm_classify: format too narrow");
   end

   always_comb begin
      exp_ones = &val[W-2:FRAC_W];
      exp_zero = ~|val[W-2:FRAC_W];
      frac_nz  = |val[FRAC_W-1:0];
      frac_top = val[FRAC_W-1];
      cls.sign = val[W-1];
      cls.zero = exp_zero & ~frac_nz;
      cls.inf  = exp_ones & ~frac_nz;
      cls.qnan = exp_ones & frac_nz & frac_top;
      cls.snan = exp_ones & frac_nz & ~frac_top;
   end

endmodule

// File: rtl/fmm_nan_pick.sv
module fmm_nan_pick
   import fmm_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W:0] a,
   input  logic [EXP_W+FRAC_W:0] b,
   input  fmm_cls_t              ca,
   input  fmm_cls_t              cb,
   output logic                  nan_hit,
   output logic [EXP_W+FRAC_W:0] nan_val
);
   localparam int W    = 1 + EXP_W + FRAC_W;
   localparam int QBIT = FRAC_W - 1;
   localparam logic [W-1:0] QMASK = {{(W-1){1'b0}}, 1'b1} << QBIT;

   // Fixed order: signalling A, signalling B, quiet A, quiet B
   always_comb begin
      nan_hit = 1'b1;
      if (ca.snan)      nan_val = a | QMASK;
      else if (cb.snan) nan_val = b | QMASK;
      else if (ca.qnan) nan_val = a;
      else if (cb.qnan) nan_val = b;
      else begin
         nan_hit = 1'b0;
         nan_val = '0;
      end
   end

endmodule

// File: rtl/fmm_order.sv
module fmm_order
   import fmm_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W:0] a,
   input  logic [EXP_W+FRAC_W:0] b,
   input  fmm_cls_t              ca,
   input  fmm_cls_t              cb,
   input  logic                  pick_min,
   output logic [EXP_W+FRAC_W:0] chosen
);
   localparam int W = 1 + EXP_W + FRAC_W;

   logic [W-2:0] mag_a;
   logic [W-2:0] mag_b;
   logic         a_above;
   logic         zero_sign;

   always_comb begin
      mag_a = a[W-2:0];
      mag_b = b[W-2:0];
      // Sign-magnitude ordering; both-negative reverses the magnitude compare
      if (ca.sign != cb.sign)  a_above = ~ca.sign;
      else if (!ca.sign)       a_above = (mag_a > mag_b);
      else                     a_above = (mag_a < mag_b);

      zero_sign = pick_min ? (ca.sign | cb.sign) : (ca.sign & cb.sign);

      if (ca.zero && cb.zero)  chosen = {zero_sign, {(W-1){1'b0}}};
      else if (pick_min)       chosen = a_above ? b : a;
      else                     chosen = a_above ? a : b;
   end

   // p_zero_result_r5 / r6: two zeros in give a zero out
   always_comb begin
      if (ca.zero && cb.zero) begin
         p_zero_result_r6: assert (chosen[W-2:0] == '0)
            else $error("two zeros produced a nonzero magnitude");
      end
   end

endmodule

// File: rtl/fmm_lane.sv
module fmm_lane
   import fmm_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [1:0]            func,
   input  logic [EXP_W+FRAC_W:0] a,
   input  logic [EXP_W+FRAC_W:0] b,
   output logic [EXP_W+FRAC_W:0] y,
   output logic                  sig_nan
);
   localparam int W = 1 + EXP_W + FRAC_W;

   fmm_cls_t     raw_ca, raw_cb;
   fmm_cls_t     sub_ca, sub_cb;
   logic [W-1:0] sub_a, sub_b;
   logic [W-1:0] loser_inf;
   fmm_cls_t     loser_cls;
   logic         lone_a, lone_b;
   logic         nan_hit;
   logic [W-1:0] nan_val;
   logic [W-1:0] ord_val;

   fmm_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_a (.val(a), .cls(raw_ca));
   fmm_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_b (.val(b), .cls(raw_cb));

   // Number-preferring forms: a lone quiet NaN becomes the infinity that always loses
   always_comb begin
      lone_a    = fmm_prefers_num(func) & raw_ca.qnan & ~raw_cb.qnan;
      lone_b    = fmm_prefers_num(func) & raw_cb.qnan & ~raw_ca.qnan;
      loser_inf = {~fmm_wants_min(func), {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      loser_cls = '{sign: ~fmm_wants_min(func), zero: 1'b0, inf: 1'b1,
                    qnan: 1'b0, snan: 1'b0};
      sub_a     = lone_a ? loser_inf : a;
      sub_b     = lone_b ? loser_inf : b;
      sub_ca    = lone_a ? loser_cls : raw_ca;
      sub_cb    = lone_b ? loser_cls : raw_cb;
   end

   fmm_nan_pick #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_nan (
      .a(sub_a), .b(sub_b), .ca(sub_ca), .cb(sub_cb),
      .nan_hit(nan_hit), .nan_val(nan_val)
   );

   fmm_order #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_ord (
      .a(sub_a), .b(sub_b), .ca(sub_ca), .cb(sub_cb),
      .pick_min(fmm_wants_min(func)), .chosen(ord_val)
   );

   always_comb begin
      y       = nan_hit ? nan_val : ord_val;
      sig_nan = raw_ca.snan | raw_cb.snan;
   end

   always_comb begin
      // R3: a signalling input always leaves as a quiet NaN
      if (raw_ca.snan || raw_cb.snan) begin
         p_snan_quieted_r3: assert ((&y[W-2:FRAC_W]) && y[FRAC_W-1])
            else $error("signalling input did not yield a quiet NaN");
      end
      // R4: two quiet NaNs return operand A untouched
      if (raw_ca.qnan && raw_cb.qnan) begin
         p_first_quiet_r4: assert (y == a)
            else $error("two quiet NaNs did not return operand A");
      end
      // R1: ordinary pairs return one of the operands bit-exactly
      if (!raw_ca.qnan && !raw_ca.snan && !raw_cb.qnan && !raw_cb.snan
          && !(raw_ca.zero && raw_cb.zero)) begin
         p_pick_operand_r1: assert (y == a || y == b)
            else $error("ordinary pair returned a value that is neither operand");
      end
      // R7: a lone quiet NaN under a number-preferring code never reaches the result
      if (fmm_prefers_num(func) && (raw_ca.qnan ^ raw_cb.qnan)
          && !raw_ca.snan && !raw_cb.snan) begin
         p_lone_qnan_dropped_r7: assert (y == (raw_ca.qnan ? b : a))
            else $error("lone quiet NaN was not treated as missing");
      end
   end

endmodule

// File: rtl/fp_minmax_unit.sv
module fp_minmax_unit
   import fmm_pkg::*;
#(
   parameter int NARROW_EXP  = 8,
   parameter int NARROW_FRAC = 23,
   parameter int WIDE_EXP    = 11,
   parameter int WIDE_FRAC   = 52
) (
   input  logic [1:0]                      func_sel,
   input  logic                            is_double,
   input  logic [WIDE_EXP+WIDE_FRAC:0]     opnd_a,
   input  logic [WIDE_EXP+WIDE_FRAC:0]     opnd_b,
   output logic [WIDE_EXP+WIDE_FRAC:0]     result,
   output logic                            invalid
);
   localparam int NW = 1 + NARROW_EXP + NARROW_FRAC;
   localparam int WW = 1 + WIDE_EXP + WIDE_FRAC;
   localparam int PAD_W = WW - NW;

   if (NW > WW) begin : g_bad_widths
      $error("fp_minmax_unit: narrow format wider than the port");
   end

   logic [NW-1:0] n_res;
   logic          n_inv;
   logic [WW-1:0] w_res;
   logic          w_inv;
   logic [WW-1:0] n_res_ext;

   fmm_lane #(.EXP_W(NARROW_EXP), .FRAC_W(NARROW_FRAC)) u_lane_n (
      .func(func_sel), .a(opnd_a[NW-1:0]), .b(opnd_b[NW-1:0]),
      .y(n_res), .sig_nan(n_inv)
   );

   fmm_lane #(.EXP_W(WIDE_EXP), .FRAC_W(WIDE_FRAC)) u_lane_w (
      .func(func_sel), .a(opnd_a), .b(opnd_b),
      .y(w_res), .sig_nan(w_inv)
   );

   if (PAD_W > 0) begin : g_pad
      assign n_res_ext = {{PAD_W{1'b0}}, n_res};
   end else begin : g_nopad
      assign n_res_ext = n_res;
   end

   always_comb begin
      result  = is_double ? w_res : n_res_ext;
      invalid = is_double ? w_inv : n_inv;
   end

   logic port_snan_a, port_snan_b;
   always_comb begin
      port_snan_a = is_double
         ? ((&opnd_a[WW-2:WIDE_FRAC]) && !opnd_a[WIDE_FRAC-1] && (|opnd_a[WIDE_FRAC-1:0]))
         : ((&opnd_a[NW-2:NARROW_FRAC]) && !opnd_a[NARROW_FRAC-1] && (|opnd_a[NARROW_FRAC-1:0]));
      port_snan_b = is_double
         ? ((&opnd_b[WW-2:WIDE_FRAC]) && !opnd_b[WIDE_FRAC-1] && (|opnd_b[WIDE_FRAC-1:0]))
         : ((&opnd_b[NW-2:NARROW_FRAC]) && !opnd_b[NARROW_FRAC-1] && (|opnd_b[NARROW_FRAC-1:0]));
      // R10: invalid follows the signalling inputs of the selected format
      p_invalid_match_r10: assert (invalid == (port_snan_a || port_snan_b))
         else $error("invalid disagrees with the operand encodings");
      // R9: narrow results leave the upper bits clear
      if (!is_double && PAD_W > 0) begin
         p_upper_clear_r9: assert (result[WW-1:NW] == '0)
            else $error("upper result bits set in narrow mode");
      end
   end

endmodule

// File: tb/sim_fp_minmax_unit.sv
module sim_fp_minmax_unit;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [1:0]  fn;
      logic        dbl;
      logic [63:0] a;
      logic [63:0] b;
      logic [63:0] y;
      logic        inv;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 38;
   // Codes: 0 MAX, 1 MIN, 2 MAXNUM, 3 MINNUM
   localparam vec_t VEC [NV] = '{
      '{2'd0, 1'b0, 64'h7F7FFFFF, 64'h807FFFFF, 64'h7F7FFFFF, 1'b0, 8'd1},
      '{2'd1, 1'b0, 64'h7F7FFFFF, 64'h807FFFFF, 64'h807FFFFF, 1'b0, 8'd1},
      '{2'd0, 1'b0, 64'h3F800000, 64'h40000000, 64'h40000000, 1'b0, 8'd1},
      '{2'd1, 1'b0, 64'h3F800000, 64'h40000000, 64'h3F800000, 1'b0, 8'd1},
      '{2'd0, 1'b0, 64'hBF800000, 64'hC0000000, 64'hBF800000, 1'b0, 8'd1},
      '{2'd1, 1'b0, 64'hBF800000, 64'hC0000000, 64'hC0000000, 1'b0, 8'd1},
      '{2'd1, 1'b0, 64'h80000001, 64'h80000002, 64'h80000002, 1'b0, 8'd1},
      '{2'd0, 1'b0, 64'h00000000, 64'hBF800000, 64'h00000000, 1'b0, 8'd1},
      '{2'd1, 1'b0, 64'h80000000, 64'h3F800000, 64'h80000000, 1'b0, 8'd1},
      '{2'd0, 1'b0, 64'h7FC00000, 64'h3F800000, 64'h7FC00000, 1'b0, 8'd2},
      '{2'd0, 1'b0, 64'h3F800000, 64'h7FC00000, 64'h7FC00000, 1'b0, 8'd2},
      '{2'd0, 1'b0, 64'h7FC00042, 64'h7F800001, 64'h7FC00001, 1'b1, 8'd2},
      '{2'd1, 1'b0, 64'h7F800005, 64'h7F800007, 64'h7FC00005, 1'b1, 8'd2},
      '{2'd0, 1'b0, 64'h7F800001, 64'h7FC00042, 64'h7FC00001, 1'b1, 8'd3},
      '{2'd1, 1'b0, 64'hFF812345, 64'h3F800000, 64'hFFC12345, 1'b1, 8'd3},
      '{2'd1, 1'b0, 64'h7FC0000A, 64'h7FC0000B, 64'h7FC0000A, 1'b0, 8'd4},
      '{2'd0, 1'b0, 64'hFFC0000B, 64'h7FC0000A, 64'hFFC0000B, 1'b0, 8'd4},
      '{2'd0, 1'b0, 64'h00000000, 64'h80000000, 64'h00000000, 1'b0, 8'd5},
      '{2'd0, 1'b0, 64'h80000000, 64'h00000000, 64'h00000000, 1'b0, 8'd5},
      '{2'd0, 1'b0, 64'h80000000, 64'h80000000, 64'h80000000, 1'b0, 8'd5},
      '{2'd1, 1'b0, 64'h00000000, 64'h80000000, 64'h80000000, 1'b0, 8'd6},
      '{2'd1, 1'b0, 64'h80000000, 64'h00000000, 64'h80000000, 1'b0, 8'd6},
      '{2'd1, 1'b0, 64'h00000000, 64'h00000000, 64'h00000000, 1'b0, 8'd6},
      '{2'd2, 1'b0, 64'h7FC00000, 64'h3F800000, 64'h3F800000, 1'b0, 8'd7},
      '{2'd2, 1'b0, 64'h3F800000, 64'h7FC00000, 64'h3F800000, 1'b0, 8'd7},
      '{2'd3, 1'b0, 64'h7FC00000, 64'hBF800000, 64'hBF800000, 1'b0, 8'd7},
      '{2'd2, 1'b0, 64'h7FC00000, 64'hFF800000, 64'hFF800000, 1'b0, 8'd7},
      '{2'd3, 1'b0, 64'h7F800000, 64'h7FC00000, 64'h7F800000, 1'b0, 8'd7},
      '{2'd2, 1'b0, 64'h7FC00000, 64'h7F800001, 64'h7FC00001, 1'b1, 8'd8},
      '{2'd3, 1'b0, 64'h7FC0000A, 64'h7FC0000B, 64'h7FC0000A, 1'b0, 8'd8},
      '{2'd0, 1'b0, 64'hDEADBEEF3F800000, 64'h1234567840000000, 64'h0000000040000000, 1'b0, 8'd9},
      '{2'd0, 1'b0, 64'h7FF0000000000001, 64'hFFF0000100000000, 64'h0000000000000001, 1'b0, 8'd9},
      '{2'd0, 1'b1, 64'h0000000000000000, 64'h8000000000000000, 64'h0000000000000000, 1'b0, 8'd5},
      '{2'd1, 1'b1, 64'h0000000000000000, 64'h8000000000000000, 64'h8000000000000000, 1'b0, 8'd6},
      '{2'd0, 1'b1, 64'h7FF0000000000001, 64'h3FF0000000000000, 64'h7FF8000000000001, 1'b1, 8'd3},
      '{2'd1, 1'b1, 64'h3FF0000000000000, 64'hC000000000000000, 64'hC000000000000000, 1'b0, 8'd1},
      '{2'd3, 1'b1, 64'h7FF8000000000000, 64'h4000000000000000, 64'h4000000000000000, 1'b0, 8'd7},
      '{2'd0, 1'b1, 64'h000000007F800001, 64'h0000000000000000, 64'h000000007F800001, 1'b0, 8'd10}
   };

   logic        clk = 1'b0;
   logic [1:0]  func_sel = 2'd0;
   logic        is_double = 1'b0;
   logic [63:0] opnd_a = '0;
   logic [63:0] opnd_b = '0;
   logic [63:0] result;
   logic        invalid;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fp_minmax_unit u0 (
      .func_sel(func_sel), .is_double(is_double),
      .opnd_a(opnd_a), .opnd_b(opnd_b),
      .result(result), .invalid(invalid)
   );

   task automatic run_one(input logic [1:0] fn, input logic dbl,
                          input logic [63:0] a, input logic [63:0] b,
                          input logic [63:0] y, input logic inv, input int req);
      @(negedge clk);
      func_sel  = fn;
      is_double = dbl;
      opnd_a    = a;
      opnd_b    = b;
      #1;
      checks++;
      if (result !== y) begin
         fails++;
         $display("FAIL R%0d result: fn=%0d a=%h b=%h actual=%h expected=%h",
                  req, fn, a, b, result, y);
      end
      checks++;
      if (invalid !== inv) begin
         fails++;
         $display("FAIL R%0d invalid: fn=%0d a=%h b=%h actual=%b expected=%b",
                  req, fn, a, b, invalid, inv);
      end
   endtask

   initial begin
      // Idle state: zero operands under the maximum code give +0, no invalid (R5, R10)
      #(CLK_PERIOD);
      run_one(2'd0, 1'b0, 64'h0, 64'h0, 64'h0, 1'b0, 5);

      for (int i = 0; i < NV; i++)
         run_one(VEC[i].fn, VEC[i].dbl, VEC[i].a, VEC[i].b, VEC[i].y, VEC[i].inv, int'(VEC[i].req));

      // R10: narrow mode ignores a signalling pattern that sits only in the upper half
      run_one(2'd1, 1'b0, 64'h7FF0000100000000, 64'h0000000000000000,
              64'h0000000000000000, 1'b0, 10);
      // R10: the same upper pattern is a signalling NaN in wide mode; R3 quiets it
      run_one(2'd1, 1'b1, 64'h7FF0000100000000, 64'h0000000000000000,
              64'h7FF8000100000000, 1'b1, 10);
      // R8: signalling B beats quiet A under min-number as well
      run_one(2'd3, 1'b1, 64'h7FF8000000000005, 64'hFFF0000000000009,
              64'hFFF8000000000009, 1'b1, 8);
      // R2: signalling A beats signalling B in wide mode
      run_one(2'd0, 1'b1, 64'h7FF0000000000003, 64'h7FF0000000000004,
              64'h7FF8000000000003, 1'b1, 2);
      // R9: narrow NaN output carries no upper bits
      run_one(2'd0, 1'b0, 64'hFFFFFFFF7F800001, 64'hFFFFFFFF00000000,
              64'h000000007FC00001, 1'b1, 9);

      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule